// File: doc/BRIEF.md
# SDLC Loop Secondary Station Controller

This block sits on one station of a serial loop in which every station repeats the line. At first it is off the loop, and the received bit stream goes straight to the transmit pin. Software asks it to join the loop. It then waits for the next end-of-poll pattern on the received stream and adds a one-bit delay, so that each received bit is sent one bit period later. Software asks it to leave in the same way. The block then drops the delay at the next end-of-poll pattern.

A station that is on the loop can take the line. When the seize request is set, the block waits for the next end-of-poll pattern and transmits a zero in place of its seventh one. The line then carries an opening flag, and the block stops repeating the received stream. It sends the frames that an external serial source offers. Whenever no frame is ready it sends flags back to back, so it keeps the line. When the seize request is withdrawn and the source is empty, the block sends one last flag and returns to repeating the received stream with the one-bit delay. Because the upstream line idles at one, the line then carries a fresh end-of-poll pattern. Bit stuffing, CRC and receive framing are handled outside this block.

All activity advances only on cycles in which the bit-clock enable is high.

Top module: `loop_station`

## Requirements
- R1: After reset the block is off the loop (`on_loop`=0, `sending`=0), and `txd` equals `rxd` in the same cycle, with no delay.
- R2: An end-of-poll pattern is the received bit sequence 0,1,1,1,1,1,1,1 (a zero followed by seven ones, first bit received first). While off the loop with join requested, the block goes on the loop at the enable edge that shifts in the seventh one. From the next bit period on, `txd` carries the `rxd` value of the previous bit period.
- R3: While on the loop (not sending) with join withdrawn, the block goes off the loop at the next end-of-poll pattern, and `txd` follows `rxd` directly again.
- R4: While `loop_en` is 0, the join and seize requests have no effect: end-of-poll patterns leave the block off the loop.
- R5: While on the loop with seize requested, the bit period that would have repeated the seventh one of an end-of-poll pattern carries 0 on `txd`, and `sending` is 1 from that period on. A seize request has no effect while off the loop.
- R6: While sending with no frame available, `txd` carries unbroken flags (0,1,1,1,1,1,1,0).
- R7: Frame bits appear on `txd` in source order, one per bit period. `tx_pop` is high for exactly one enable cycle per frame bit, and a closing flag follows each frame's last bit (the bit marked by `tx_last`).
- R8: With `shared_flags`=1, a queued frame starts right after the previous frame's closing flag (8 bit periods between frames). With `shared_flags`=0, an extra opening flag comes between them (16 bit periods).
- R9: When seize is withdrawn and no frame is available at the end of a flag, the block stops sending, stays on the loop, and repeats `rxd` with one bit of delay. Idle-one input then yields the pattern 0 followed by seven ones on `txd`.
- R10: A seize request withdrawn while a frame is still available does not stop transmission: the pending frame is sent in full before the release.
- R11: On cycles with `bit_en`=0 no state changes, and `tx_pop` stays 0.
- R12: Eight or more ones that have no zero before them are not taken as an end-of-poll pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable, one cycle per line bit |
| rxd | input | 1 | Received line bit |
| loop_en | input | 1 | Loop operation enable; gates both requests |
| go_on_loop | input | 1 | Join (1) or leave (0) request |
| go_active | input | 1 | Seize (1) or release (0) request |
| shared_flags | input | 1 | Closing flag doubles as the next opening flag |
| tx_avail | input | 1 | Serial frame source has a bit ready |
| tx_bit | input | 1 | Current frame bit from the source |
| tx_last | input | 1 | Current frame bit is the frame's last |
| txd | output | 1 | Transmitted line bit |
| tx_pop | output | 1 | Current source bit consumed this enable cycle |
| on_loop | output | 1 | Block is on the loop (delay inserted or sending) |
| sending | output | 1 | Block holds the line |

## Verification
Off the loop, `txd` follows `rxd` within the same cycle. Every other result takes effect at an enable edge and appears on the outputs for the whole of the following bit period. That covers the mode flags after an end-of-poll pattern, the forced zero, each flag bit and each frame bit. `tx_pop` is combinational within the enable cycle that consumes the bit. The bench drives each input at a falling edge and compares all four outputs one nanosecond later against a behavioural model. The model advances only after that comparison, so each expected value belongs to the bit period that is on the line. Spacing between frames is measured in counted bit periods between pops, and the forced zero and the released end-of-poll are read from a log of the last eight line bits.

// File: rtl/loop_pkg.sv
package loop_pkg;
    localparam int PAT_W = 8;

    typedef enum logic [1:0] {
        M_OFF  = 2'd0,
        M_ON   = 2'd1,
        M_SEND = 2'd2
    } mode_e;

    typedef enum logic {
        PH_FLAG = 1'b0,
        PH_DATA = 1'b1
    } phase_e;
endpackage

// File: rtl/loop_eop_det.sv
module loop_eop_det #(
    parameter int PAT_W = loop_pkg::PAT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rxd,
    output logic eop
);
    localparam logic [PAT_W-1:0] EOP_PAT = {1'b0, {(PAT_W-1){1'b1}}};

    logic [PAT_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (bit_en) begin
            hist_d = {hist_q[PAT_W-2:0], rxd};
        end
    end

    assign eop = bit_en && (hist_d == EOP_PAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else begin
            hist_q <= hist_d;
        end
    end

    // A detected pattern ends in a one, so the next window cannot match.
    assert_eop_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eop |=> !eop);
    assert_eop_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> (rxd && bit_en));
endmodule

// File: rtl/loop_flag_gen.sv
module loop_flag_gen #(
    parameter int PAT_W = loop_pkg::PAT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic start,
    input  logic run,
    input  logic shared_flags,
    input  logic hold,
    input  logic tx_avail,
    input  logic tx_bit,
    input  logic tx_last,
    output logic ser_bit,
    output logic hand_back,
    output logic tx_pop
);
    import loop_pkg::*;

    localparam int CNT_W = $clog2(PAT_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAT_W - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] idx;
        logic             closing;
        logic             last;
        logic             bit_out;
    } ser_t;

    ser_t st_d, st_q;

    function automatic logic flag_bit(input logic [CNT_W-1:0] i);
        return (i != '0) && (i != LAST_IDX);
    endfunction

    always_comb begin
        st_d      = st_q;
        hand_back = 1'b0;
        tx_pop    = 1'b0;
        if (bit_en) begin
            if (start) begin
                // The forced zero is the last bit of the opening flag.
                st_d.phase   = PH_FLAG;
                st_d.idx     = LAST_IDX;
                st_d.closing = 1'b0;
                st_d.last    = 1'b0;
                st_d.bit_out = 1'b0;
            end else if (run) begin
                case (st_q.phase)
                    PH_DATA: begin
                        if (st_q.last || !tx_avail) begin
                            st_d.phase   = PH_FLAG;
                            st_d.idx     = '0;
                            st_d.closing = 1'b1;
                            st_d.bit_out = flag_bit('0);
                        end else begin
                            st_d.bit_out = tx_bit;
                            st_d.last    = tx_last;
                            tx_pop       = 1'b1;
                        end
                    end
                    default: begin
                        if (st_q.idx != LAST_IDX) begin
                            st_d.idx     = st_q.idx + 1'b1;
                            st_d.bit_out = flag_bit(st_q.idx + 1'b1);
                        end else if (!hold && !tx_avail) begin
                            hand_back = 1'b1;
                        end else if (tx_avail && (shared_flags || !st_q.closing)) begin
                            st_d.phase   = PH_DATA;
                            st_d.bit_out = tx_bit;
                            st_d.last    = tx_last;
                            tx_pop       = 1'b1;
                        end else begin
                            st_d.idx     = '0;
                            st_d.closing = 1'b0;
                            st_d.bit_out = flag_bit('0);
                        end
                    end
                endcase
            end
        end
    end

    assign ser_bit = st_q.bit_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_FLAG, idx: '0, closing: 1'b0, last: 1'b0, bit_out: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assert_closing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && run && !start && st_q.phase == PH_DATA && st_q.last)
        |=> (!ser_bit && st_q.phase == PH_FLAG));
    assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && run && !start && st_q.phase == PH_FLAG && st_q.idx == '0)
        |=> ser_bit);
    assert_pop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |-> !tx_pop);
endmodule

// File: rtl/loop_station.sv
module loop_station #(
    parameter int PAT_W = loop_pkg::PAT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rxd,
    input  logic loop_en,
    input  logic go_on_loop,
    input  logic go_active,
    input  logic shared_flags,
    input  logic tx_avail,
    input  logic tx_bit,
    input  logic tx_last,
    output logic txd,
    output logic tx_pop,
    output logic on_loop,
    output logic sending
);
    import loop_pkg::*;

    typedef struct packed {
        mode_e mode;
        logic  dly;
    } top_t;

    top_t st_d, st_q;
    logic eop, on_eff, act_eff, start, hand_back, ser_bit;

    assign on_eff  = loop_en && go_on_loop;
    assign act_eff = loop_en && go_active;

    loop_eop_det #(.PAT_W(PAT_W)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .rxd    (rxd),
        .eop    (eop)
    );

    loop_flag_gen #(.PAT_W(PAT_W)) u_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .start        (start),
        .run          (st_q.mode == M_SEND),
        .shared_flags (shared_flags),
        .hold         (act_eff),
        .tx_avail     (tx_avail),
        .tx_bit       (tx_bit),
        .tx_last      (tx_last),
        .ser_bit      (ser_bit),
        .hand_back    (hand_back),
        .tx_pop       (tx_pop)
    );

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (bit_en) begin
            st_d.dly = rxd;
            case (st_q.mode)
                M_OFF: begin
                    if (eop && on_eff) st_d.mode = M_ON;
                end
                M_ON: begin
                    if (eop && act_eff) begin
                        st_d.mode = M_SEND;
                        start     = 1'b1;
                    end else if (eop && !on_eff) begin
                        st_d.mode = M_OFF;
                    end
                end
                default: begin
                    if (hand_back) st_d.mode = M_ON;
                end
            endcase
        end
    end

    always_comb begin
        case (st_q.mode)
            M_OFF:   txd = rxd;
            M_ON:    txd = st_q.dly;
            default: txd = ser_bit;
        endcase
    end

    assign on_loop = (st_q.mode != M_OFF);
    assign sending = (st_q.mode == M_SEND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_OFF, dly: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(st_q));
    assert_seize_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_ON && eop && act_eff) |=> (sending && !txd));
    assert_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_en && st_q.mode == M_OFF) |=> !on_loop);
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && hand_back) |=> (on_loop && !sending));
endmodule

// File: tb/sim_loop_station.sv
module sim_loop_station;
    localparam time CLK_HALF = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, rxd = 1'b1, loop_en = 1'b0, go_on_loop = 1'b0;
    logic go_active = 1'b0, shared_flags = 1'b0;
    logic tx_avail = 1'b0, tx_bit = 1'b0, tx_last = 1'b0;
    logic txd, tx_pop, on_loop, sending;

    loop_station u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rxd(rxd),
        .loop_en(loop_en), .go_on_loop(go_on_loop), .go_active(go_active),
        .shared_flags(shared_flags), .tx_avail(tx_avail), .tx_bit(tx_bit),
        .tx_last(tx_last), .txd(txd), .tx_pop(tx_pop), .on_loop(on_loop),
        .sending(sending)
    );

    always #(CLK_HALF) clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    // frame source
    int sq[$];
    int fl[$];
    // reference model: 0 off, 1 on, 2 sending
    int m_mode = 0, m_hist = 255, m_dly = 1, m_out = 0, m_unit = 0;
    int m_plan[$];
    int step_no = 0, tail = 0;
    int pop_steps[$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input bit en, input bit rx);
        int e_txd, e_on, e_send, e_pop, nh, code, old_mode;
        bit eop, act, jn, avail;
        string tg;
        @(negedge clk);
        bit_en = en;
        rxd = rx;
        tx_avail = sq.size() > 0;
        tx_bit = tx_avail ? 1'(sq[0]) : 1'b0;
        tx_last = tx_avail && (fl[0] == 1);
        #1;
        old_mode = m_mode;
        e_txd = (m_mode == 0) ? int'(rx) : ((m_mode == 1) ? m_dly : m_out);
        e_on = (m_mode != 0);
        e_send = (m_mode == 2);
        e_pop = 0;
        if (en) begin
            nh = ((m_hist << 1) | int'(rx)) & 255;
            eop = (nh == 127);
            act = loop_en && go_active;
            jn = loop_en && go_on_loop;
            avail = sq.size() > 0;
            if (m_mode == 0) begin
                if (eop && jn) m_mode = 1;
            end else if (m_mode == 1) begin
                if (eop && act) begin
                    m_mode = 2; m_out = 0; m_unit = 0; m_plan.delete();
                end else if (eop && !jn) m_mode = 0;
            end else begin
                if (m_plan.size() == 0) begin
                    if (m_unit == 2) begin
                        m_plan = '{0, 1, 1, 1, 1, 1, 1, 0};
                        m_unit = 1;
                    end else if (!act && !avail) begin
                        m_mode = 1;
                    end else if (avail && (shared_flags || m_unit == 0)) begin
                        for (int i = 0; i < fl[0]; i++) m_plan.push_back(2);
                        m_unit = 2;
                    end else begin
                        m_plan = '{0, 1, 1, 1, 1, 1, 1, 0};
                        m_unit = 0;
                    end
                end
                if (m_mode == 2) begin
                    code = m_plan.pop_front();
                    if (code == 2) begin
                        m_out = sq[0];
                        e_pop = 1;
                    end else m_out = code;
                end
            end
            m_dly = rx;
            m_hist = nh;
        end
        if (!en) tg = "R11";
        else if (old_mode == 0) tg = "R1";
        else if (old_mode == 1) tg = "R2";
        else tg = "R6";
        chk({tg, " txd"}, int'(txd), e_txd);
        chk({tg, " on_loop"}, int'(on_loop), e_on);
        chk({tg, " sending"}, int'(sending), e_send);
        chk(en ? "R7 tx_pop" : "R11 tx_pop", int'(tx_pop), e_pop);
        if (en) begin
            tail = ((tail << 1) | int'(txd)) & 255;
            step_no++;
        end
        @(posedge clk);
        #1;
        if (e_pop) begin
            void'(sq.pop_front());
            fl[0] = fl[0] - 1;
            if (fl[0] == 0) void'(fl.pop_front());
            pop_steps.push_back(step_no);
        end
    endtask

    task automatic bit_(input bit rx);
        tick(1'b1, rx);
        tick(1'b0, rx);
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) bit_(1'b1);
    endtask

    task automatic eop_seq();
        bit_(1'b0);
        ones(7);
    endtask

    task automatic push_frame(input int len, input int pat);
        for (int i = 0; i < len; i++) sq.push_back((pat >> i) & 1);
        fl.push_back(len);
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset on_loop", int'(on_loop), 0);
        chk("R1 reset sending", int'(sending), 0);
        bit_(1'b0); bit_(1'b1); bit_(1'b0);

        // R4: requests ignored without loop enable
        go_on_loop = 1'b1; go_active = 1'b1;
        eop_seq(); eop_seq();
        chk("R4 on_loop", int'(on_loop), 0);

        // R12: long run of ones is not an end-of-poll
        loop_en = 1'b1; go_active = 1'b0;
        ones(10);
        chk("R12 on_loop", int'(on_loop), 0);

        // R2: join at end-of-poll
        eop_seq();
        chk("R2 on_loop", int'(on_loop), 1);
        bit_(1'b0); bit_(1'b1); bit_(1'b0); ones(4);

        // R5: seize, forced zero position
        go_active = 1'b1;
        eop_seq();
        chk("R5 sending", int'(sending), 1);
        bit_(1'b1);
        chk("R5 forced zero", tail & 1, 0);
        chk("R5 opening flag", tail, 8'h7E);

        // R6: flag fill
        ones(8);
        chk("R6 fill flag 1", tail, 8'h7E);
        ones(8);
        chk("R6 fill flag 2", tail, 8'h7E);

        // R8 unshared, R7 frames
        pop_steps.delete();
        push_frame(5, 5'b10110);
        push_frame(6, 6'b011101);
        ones(60);
        chk("R7 pop count", pop_steps.size(), 11);
        if (pop_steps.size() == 11)
            chk("R8 unshared gap", pop_steps[5] - pop_steps[4] - 1, 16);

        // R8 shared
        shared_flags = 1'b1;
        pop_steps.delete();
        push_frame(4, 4'b1001);
        push_frame(5, 5'b11111);
        ones(50);
        chk("R7 pop count shared", pop_steps.size(), 9);
        if (pop_steps.size() == 9)
            chk("R8 shared gap", pop_steps[4] - pop_steps[3] - 1, 8);

        // R10: release withdrawn with data pending
        pop_steps.delete();
        push_frame(7, 7'b0101101);
        go_active = 1'b0;
        for (int i = 0; i < 60 && sending; i++) bit_(1'b1);
        chk("R10 pending frame sent", pop_steps.size(), 7);
        chk("R9 on_loop after release", int'(on_loop), 1);
        chk("R9 sending after release", int'(sending), 0);
        ones(7);
        chk("R9 end-of-poll formed", tail, 8'h7F);

        // R3: leave loop
        go_on_loop = 1'b0;
        eop_seq();
        chk("R3 on_loop", int'(on_loop), 0);
        bit_(1'b0); bit_(1'b1);

        // R5: seize ignored while off loop
        go_active = 1'b1;
        eop_seq();
        chk("R5 seize ignored off loop", int'(sending), 0);
        bit_(1'b0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule